// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock timing of an SPI engine from the system clock. The system clock is halved first. An optional sixteen-fold stage may follow. A programmable modulus counter comes next, and a final toggle stage gives a square clock with equal high and low times. The block does not drive a clock pin. It emits single-cycle strobes that tell the shifter when the serial clock goes high and when it goes low, together with the current clock level. Clock polarity and phase are left to the shifter.

The divider settings come from the mode word of the selected chip-select. Bit 28 of that word switches in the sixteen-fold stage. Bits 27:24 hold the modulus. The block captures both fields in the cycle a new command is loaded and keeps them for the whole command. Every counter in the chain restarts from zero when a command is loaded and is held at zero while the engine enable is low. Each command therefore begins with a full half-period.

Top module: `spi_baud_gen`

## Requirements
- R1: Under reset, and after reset before any counting, `sck_rise_o`, `sck_fall_o` and `sck_level_o` are all 0.
- R2: With mode-word bit 28 clear and modulus M in bits 27:24, the level toggles every 2*(M+1) system clock cycles. Counting is taken from the clock edge that samples `cmd_load` high.
- R3: With mode-word bit 28 set, each half-period is 16 times longer, 32*(M+1) cycles.
- R4: After a load the first toggle is a rise. Rises and falls then alternate. `sck_level_o` is 1 from each rise until the next fall, giving a 50% duty cycle.
- R5: Each strobe is high for exactly one cycle, in the same cycle that `sck_level_o` first shows the new level. The two strobes are never high together.
- R6: Bits 28 and 27:24 are sampled only in the cycle `cmd_load` is high. Changing `cfg_word` at any other time has no effect on the strobe timing.
- R7: While `eng_en` is low, no strobe occurs and the level is 0. When enable returns, counting restarts from zero with the captured settings. The first rise comes one full half-period after the last edge that sampled enable low.
- R8: A `cmd_load` during a running command restarts the chain from zero with the newly sampled settings.
- R9: At the slowest setting (bit 28 set, modulus 15) the half-period is 512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_en | input | 1 | Engine enable; low clears and holds the divider |
| cmd_load | input | 1 | One-cycle pulse when a new command starts |
| cfg_word | input | 32 | Chip-select mode word (bit 28 slow stage, bits 27:24 modulus) |
| sck_rise_o | output | 1 | Strobe: serial clock goes high |
| sck_fall_o | output | 1 | Strobe: serial clock goes low |
| sck_level_o | output | 1 | Current serial clock level |

## Verification
The bench aims at the first strobe after a load. A divider that is one cycle off, or that carries stale counter state into a new command, puts that strobe in the wrong cycle and lengthens or shortens the opening half-period. Modulus zero and modulus fifteen are the extremes of the counter. A compare against the wrong boundary there either drops a toggle or adds one. Changing the mode word during a command would show up as a design that reads the settings live, because the toggle spacing would change partway through. The bench also drops the enable partway through a command. A design that only pauses, instead of clearing, would then toggle early after re-enable.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  // Half-period in system clock cycles for a given setting.
  function automatic int unsigned half_cycles(bit slow, int unsigned modv,
                                              int unsigned pre_w);
    int unsigned pre;
    pre = slow ? (32'd1 << pre_w) : 32'd1;
    return 2 * pre * (modv + 1);
  endfunction
endpackage

// File: rtl/baud_cfg_latch.sv
module baud_cfg_latch #(
  parameter int CFG_W    = 32,
  parameter int MOD_W    = 4,
  parameter int MOD_LSB  = 24,
  parameter int SLOW_BIT = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             slow_o,
  output logic [MOD_W-1:0] mod_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_o <= 1'b0;
      mod_o  <= '0;
    end else if (load) begin
      slow_o <= cfg_word[SLOW_BIT];
      mod_o  <= cfg_word[MOD_LSB +: MOD_W];
    end
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(slow_o) && $stable(mod_o)));
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick_o
);
  logic             half_q;
  logic [PRE_W-1:0] sub_q;
  logic             base_tick;

  assign base_tick = run & half_q;
  assign tick_o    = base_tick & (~slow | (&sub_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      sub_q  <= '0;
    end else if (!run) begin
      half_q <= 1'b0;
      sub_q  <= '0;
    end else begin
      half_q <= ~half_q;
      if (base_tick && slow) sub_q <= sub_q + 1'b1;
    end
  end

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!half_q && sub_q == '0));
endmodule

// File: rtl/baud_toggle.sv
module baud_toggle #(
  parameter int MOD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [MOD_W-1:0] mod_lim,
  output logic             rise_o,
  output logic             fall_o,
  output logic             level_o
);
  logic [MOD_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = tick & (cnt_q == mod_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_o <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      level_o <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) level_o <= ~level_o;
      rise_o <= wrap & ~level_o;
      fall_o <= wrap & level_o;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= mod_lim);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
  // R4
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> level_o);
  // R4
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !level_o);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!rise_o && !fall_o && !level_o));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int CFG_W    = 32,
  parameter int MOD_W    = 4,
  parameter int MOD_LSB  = 24,
  parameter int SLOW_BIT = 28,
  parameter int PRE_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_en,
  input  logic             cmd_load,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             sck_rise_o,
  output logic             sck_fall_o,
  output logic             sck_level_o
);
  logic             run;
  logic             slow_lat;
  logic [MOD_W-1:0] mod_lat;
  logic             pre_tick;

  assign run = eng_en & ~cmd_load;

  baud_cfg_latch #(
    .CFG_W(CFG_W), .MOD_W(MOD_W), .MOD_LSB(MOD_LSB), .SLOW_BIT(SLOW_BIT)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(cmd_load), .cfg_word(cfg_word),
    .slow_o(slow_lat), .mod_o(mod_lat)
  );

  baud_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(run), .slow(slow_lat), .tick_o(pre_tick)
  );

  baud_toggle #(.MOD_W(MOD_W)) tog_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(pre_tick), .mod_lim(mod_lat),
    .rise_o(sck_rise_o), .fall_o(sck_fall_o), .level_o(sck_level_o)
  );
endmodule

// File: tb/spi_baud_gen_tb_top.sv
module spi_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_en = 1'b0;
  logic        cmd_load = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        sck_rise_o, sck_fall_o, sck_level_o;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cmd_load(cmd_load),
    .cfg_word(cfg_word), .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o),
    .sck_level_o(sck_level_o)
  );

  typedef struct packed {
    logic       slow;
    logic [3:0] pm;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 4'd0}, '{1'b0, 4'd1}, '{1'b0, 4'd5},
    '{1'b0, 4'd15}, '{1'b1, 4'd0}, '{1'b1, 4'd2}
  };

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_of(bit slow, int pm);
    return (pm + 1) << (slow ? 5 : 1);
  endfunction

  // Called at a negedge; leaves the bench at the negedge after the load edge.
  task automatic load(bit slow, int pm);
    cfg_word = 32'h00A5_5A00 | (32'(slow) << 28) | (32'(pm) << 24);
    cmd_load = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_load = 1'b0;
    cfg_word = ~cfg_word; // R6: later changes must not matter
  endtask

  task automatic observe(int h, int n, string tag);
    int stray = 0;
    for (int c = 1; c <= n; c++) begin
      bit er, ef, el;
      @(posedge clk); @(negedge clk);
      el = ((c / h) % 2) == 1;
      er = (c % h == 0) && el;
      ef = (c % h == 0) && !el;
      if (er || ef) begin
        chk(sck_rise_o == er && sck_fall_o == ef, tag,
            {sck_rise_o, sck_fall_o}, {er, ef});
        chk(sck_level_o == el, "R4 level", sck_level_o, el);
      end else if (sck_rise_o || sck_fall_o || sck_level_o != el) begin
        stray++;
      end
    end
    chk(stray == 0, {tag, " R5 no stray"}, stray, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({sck_rise_o, sck_fall_o, sck_level_o} == 3'b000, "R1 in reset",
        {sck_rise_o, sck_fall_o, sck_level_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({sck_rise_o, sck_fall_o, sck_level_o} == 3'b000, "R1 after reset",
        {sck_rise_o, sck_fall_o, sck_level_o}, 0);
    eng_en = 1'b1;
    foreach (VECS[i]) begin
      int h;
      h = half_of(VECS[i].slow, VECS[i].pm);
      load(VECS[i].slow, VECS[i].pm);
      observe(h, 3 * h + 1, VECS[i].slow ? "R3" : "R2");
    end
    // R9 slowest setting
    load(1'b1, 15);
    observe(512, 1030, "R9");
    // R7 disable mid-command
    load(1'b0, 0);
    observe(2, 5, "R7 pre");
    eng_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); @(negedge clk);
      chk({sck_rise_o, sck_fall_o, sck_level_o} == 3'b000, "R7 idle",
          {sck_rise_o, sck_fall_o, sck_level_o}, 0);
    end
    eng_en = 1'b1;
    observe(2, 6, "R7");
    // R8 reload mid-command
    load(1'b0, 3);
    observe(8, 5, "R8 pre");
    load(1'b0, 0);
    observe(2, 6, "R8");
    // R1 reset during run
    load(1'b0, 0);
    observe(2, 3, "R1 pre");
    rst_n = 1'b0;
    @(negedge clk);
    chk({sck_rise_o, sck_fall_o, sck_level_o} == 3'b000, "R1 mid reset",
        {sck_rise_o, sck_fall_o, sck_level_o}, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule